// File: doc/BRIEF.md
# Store-Release Decode and Address Unit

This block sits behind instruction fetch. It looks at one 32-bit instruction word per cycle and recognises two encodings of a release-ordered register store. The first is a plain form that uses the base address as it is. The second is a pre-decrement form, which lowers the base by the access size before the access and then writes the new address back to the base. Register 31 in the base field selects the stack pointer. Register indices go straight out to an asynchronous register-file read port, and the base and source values come back in the same cycle.

For each valid word, one cycle later, the block gives exactly one outcome. The outcome is a release-flagged store request (address, data, byte count, tag-check flag) with an optional base writeback, or an undefined-instruction flag, or a no-op flag, or a stack-pointer alignment fault, or a not-matched flag. The block does not enforce memory ordering, check tags or access memory. Those jobs belong to the units that consume its outputs.

Top module: `srel_decode_unit`

## Requirements
- R1: A word with bit31=1, bits29:21=001000100, bits20:16=11111, bit15=1 and bits14:10=11111 is the plain form. It stores to the base value unchanged and never writes back.
- R2: A word with bit31=1, bits29:22=01100110, bits21:12 all zero and bits11:10=10 is the pre-decrement form. It stores to the base minus 4 (32-bit) or minus 8 (64-bit), and it writes that address to the base register. In both forms the base index is bits9:5 and the source index is bits4:0.
- R3: Bit 30 selects the size. 0 gives a 4-byte store whose data is the low 32 bits of the source register, zero-extended. 1 gives an 8-byte store of the full source register.
- R4: When feat_preidx_en is low, the pre-decrement form reports undefined and issues no store and no writeback.
- R5: In the pre-decrement form with base index equal to source index and not 31, ovl_policy selects the outcome: 0 stores the original value, 1 stores all zeros, 2 reports undefined, 3 reports a no-op.
- R6: The tag-check flag is set for the plain form only when the base index is not 31. It is always set for the pre-decrement form.
- R7: Base index 31 takes the stack pointer as the base. A writeback then goes to the stack pointer (wb_to_sp=1) and not to a general register.
- R8: When the base is the stack pointer and its low 4 bits are not all zero, the block raises align_fault and issues no store and no writeback. Undefined and no-op outcomes take priority over this check.
- R9: A valid word that matches neither form raises no_match only.
- R10: Outcomes appear on the cycle after a valid word. Every store request carries the release flag. A cycle with instr_valid low produces no outcome on the next cycle.
- R11: Directly after reset all outcome and valid flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is present |
| instr | input | 32 | Instruction word |
| feat_preidx_en | input | 1 | Enables the pre-decrement form |
| ovl_policy | input | 2 | Outcome choice for base/source overlap |
| sp_value | input | 64 | Current stack pointer |
| rd_base_idx | output | 5 | Register-file read index for the base |
| rd_src_idx | output | 5 | Register-file read index for the source |
| rf_base_data | input | 64 | Base register value |
| rf_src_data | input | 64 | Source register value |
| st_valid | output | 1 | Store request |
| st_addr | output | 64 | Store address |
| st_data | output | 64 | Store data |
| st_bytes | output | 4 | Store byte count |
| st_release | output | 1 | Release ordering flag |
| st_tagcheck | output | 1 | Tag check required |
| base_is_sp | output | 1 | Base came from the stack pointer |
| wb_valid | output | 1 | Base writeback request |
| wb_to_sp | output | 1 | Writeback targets the stack pointer |
| wb_idx | output | 5 | Writeback register index |
| wb_value | output | 64 | Writeback value |
| undef_o | output | 1 | Undefined instruction |
| nop_o | output | 1 | Treated as no-op |
| align_fault | output | 1 | Stack-pointer alignment fault |
| no_match | output | 1 | Word matched neither form |

## Verification
The assertions assume that sp_value is stable for the cycle in which a word is decoded. They also assume the register file answers within the same cycle as the read indices it is given. The bench holds every input constant from one falling edge to the next and drives the register-file data as a pure function of the indices the block emits. The sweep covers every base and source index, both sizes, both forms, every overlap policy, the feature enable, and an aligned and a misaligned stack pointer. Single-bit corruptions of both encodings then probe the not-matched path.

// File: rtl/srel_pkg.sv
package srel_pkg;

    localparam int unsigned IDX_W  = 5;
    localparam logic [IDX_W-1:0] SP_IDX = 5'd31;

    typedef enum logic [1:0] {
        OVL_KEEP  = 2'd0,
        OVL_ZERO  = 2'd1,
        OVL_UNDEF = 2'd2,
        OVL_NOP   = 2'd3
    } ovl_policy_e;

    typedef enum logic [1:0] {
        FORM_NONE   = 2'd0,
        FORM_PLAIN  = 2'd1,
        FORM_PREDEC = 2'd2
    } form_e;

    typedef enum logic [2:0] {
        OUT_IDLE    = 3'd0,
        OUT_STORE   = 3'd1,
        OUT_UNDEF   = 3'd2,
        OUT_NOP     = 3'd3,
        OUT_ALIGN   = 3'd4,
        OUT_NOMATCH = 3'd5
    } outcome_e;

endpackage

// File: rtl/srel_match.sv
module srel_match
    import srel_pkg::*;
(
    input  logic [31:0]      instr,
    output form_e            form,
    output logic [IDX_W-1:0] rn,
    output logic [IDX_W-1:0] rt,
    output logic             dword
);
    logic plain_hit;
    logic predec_hit;

    always_comb begin
        plain_hit  = instr[31] && (instr[29:21] == 9'b001000100) &&
                     (instr[20:16] == 5'b11111) && instr[15] &&
                     (instr[14:10] == 5'b11111);
        predec_hit = instr[31] && (instr[29:22] == 8'b01100110) &&
                     (instr[21:12] == 10'd0) && (instr[11:10] == 2'b10);
        if (plain_hit)       form = FORM_PLAIN;
        else if (predec_hit) form = FORM_PREDEC;
        else                 form = FORM_NONE;
        rn    = instr[9:5];
        rt    = instr[4:0];
        dword = instr[30];
    end
endmodule

// File: rtl/srel_outcome.sv
module srel_outcome
    import srel_pkg::*;
#(
    parameter int unsigned SP_ALIGN_BITS = 4
) (
    input  logic                     valid,
    input  form_e                    form,
    input  logic                     feat_en,
    input  logic [1:0]               policy,
    input  logic [IDX_W-1:0]         rn,
    input  logic [IDX_W-1:0]         rt,
    input  logic [SP_ALIGN_BITS-1:0] sp_low,
    output outcome_e                 outcome,
    output logic                     zero_data
);
    logic overlap;
    logic sp_base;

    always_comb begin
        sp_base   = (rn == SP_IDX);
        overlap   = (form == FORM_PREDEC) && (rn == rt) && !sp_base;
        zero_data = 1'b0;
        outcome   = OUT_STORE;
        if (!valid) begin
            outcome = OUT_IDLE;
        end else if (form == FORM_NONE) begin
            outcome = OUT_NOMATCH;
        end else if (form == FORM_PREDEC && !feat_en) begin
            outcome = OUT_UNDEF;
        end else if (overlap && ovl_policy_e'(policy) == OVL_UNDEF) begin
            outcome = OUT_UNDEF;
        end else if (overlap && ovl_policy_e'(policy) == OVL_NOP) begin
            outcome = OUT_NOP;
        end else if (sp_base && (sp_low != '0)) begin
            outcome = OUT_ALIGN;
        end else begin
            outcome   = OUT_STORE;
            zero_data = overlap && (ovl_policy_e'(policy) == OVL_ZERO);
        end
    end
endmodule

// File: rtl/srel_addr.sv
module srel_addr #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] base,
    input  logic            predec,
    input  logic            dword,
    output logic [XLEN-1:0] addr
);
    localparam logic [XLEN-1:0] STEP_W = XLEN'(4);
    localparam logic [XLEN-1:0] STEP_D = XLEN'(8);

    always_comb begin
        if (predec) addr = base - (dword ? STEP_D : STEP_W);
        else        addr = base;
    end
endmodule

// File: rtl/srel_decode_unit.sv
module srel_decode_unit
    import srel_pkg::*;
#(
    parameter int unsigned XLEN          = 64,
    parameter int unsigned SP_ALIGN_BITS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    input  logic            feat_preidx_en,
    input  logic [1:0]      ovl_policy,
    input  logic [XLEN-1:0] sp_value,
    output logic [4:0]      rd_base_idx,
    output logic [4:0]      rd_src_idx,
    input  logic [XLEN-1:0] rf_base_data,
    input  logic [XLEN-1:0] rf_src_data,
    output logic            st_valid,
    output logic [XLEN-1:0] st_addr,
    output logic [XLEN-1:0] st_data,
    output logic [3:0]      st_bytes,
    output logic            st_release,
    output logic            st_tagcheck,
    output logic            base_is_sp,
    output logic            wb_valid,
    output logic            wb_to_sp,
    output logic [4:0]      wb_idx,
    output logic [XLEN-1:0] wb_value,
    output logic            undef_o,
    output logic            nop_o,
    output logic            align_fault,
    output logic            no_match
);
    localparam int unsigned HALF = XLEN / 2;

    typedef struct packed {
        logic            st_valid;
        logic [XLEN-1:0] st_addr;
        logic [XLEN-1:0] st_data;
        logic [3:0]      st_bytes;
        logic            st_tagcheck;
        logic            base_is_sp;
        logic            wb_valid;
        logic            wb_to_sp;
        logic [4:0]      wb_idx;
        logic            undef_f;
        logic            nop_f;
        logic            align_f;
        logic            nomatch_f;
    } out_s;

    out_s state_d, state_q;

    form_e            form;
    logic [IDX_W-1:0] rn, rt;
    logic             dword;
    outcome_e         outcome;
    logic             zero_data;
    logic [XLEN-1:0]  base_val;
    logic [XLEN-1:0]  eff_addr;
    logic             sp_base;

    srel_match u_match (
        .instr (instr),
        .form  (form),
        .rn    (rn),
        .rt    (rt),
        .dword (dword)
    );

    srel_outcome #(.SP_ALIGN_BITS(SP_ALIGN_BITS)) u_outcome (
        .valid     (instr_valid),
        .form      (form),
        .feat_en   (feat_preidx_en),
        .policy    (ovl_policy),
        .rn        (rn),
        .rt        (rt),
        .sp_low    (sp_value[SP_ALIGN_BITS-1:0]),
        .outcome   (outcome),
        .zero_data (zero_data)
    );

    assign sp_base     = (rn == SP_IDX);
    assign base_val    = sp_base ? sp_value : rf_base_data;
    assign rd_base_idx = rn;
    assign rd_src_idx  = rt;

    srel_addr #(.XLEN(XLEN)) u_addr (
        .base   (base_val),
        .predec (form == FORM_PREDEC),
        .dword  (dword),
        .addr   (eff_addr)
    );

    always_comb begin
        state_d             = '0;
        state_d.st_valid    = (outcome == OUT_STORE);
        state_d.st_addr     = eff_addr;
        if (zero_data)  state_d.st_data = '0;
        else if (dword) state_d.st_data = rf_src_data;
        else            state_d.st_data = {{HALF{1'b0}}, rf_src_data[HALF-1:0]};
        state_d.st_bytes    = dword ? 4'd8 : 4'd4;
        state_d.st_tagcheck = (form == FORM_PREDEC) || !sp_base;
        state_d.base_is_sp  = sp_base;
        state_d.wb_valid    = (outcome == OUT_STORE) && (form == FORM_PREDEC);
        state_d.wb_to_sp    = state_d.wb_valid && sp_base;
        state_d.wb_idx      = rn;
        state_d.undef_f     = (outcome == OUT_UNDEF);
        state_d.nop_f       = (outcome == OUT_NOP);
        state_d.align_f     = (outcome == OUT_ALIGN);
        state_d.nomatch_f   = (outcome == OUT_NOMATCH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign st_valid    = state_q.st_valid;
    assign st_addr     = state_q.st_addr;
    assign st_data     = state_q.st_data;
    assign st_bytes    = state_q.st_bytes;
    assign st_release  = state_q.st_valid;
    assign st_tagcheck = state_q.st_tagcheck;
    assign base_is_sp  = state_q.base_is_sp;
    assign wb_valid    = state_q.wb_valid;
    assign wb_to_sp    = state_q.wb_to_sp;
    assign wb_idx      = state_q.wb_idx;
    assign wb_value    = state_q.st_addr;
    assign undef_o     = state_q.undef_f;
    assign nop_o       = state_q.nop_f;
    assign align_fault = state_q.align_f;
    assign no_match    = state_q.nomatch_f;
endmodule

// File: rtl/srel_decode_unit_chk.sv
module srel_decode_unit_chk #(
    parameter int unsigned XLEN          = 64,
    parameter int unsigned SP_ALIGN_BITS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic [XLEN-1:0] sp_value,
    input logic            st_valid,
    input logic [XLEN-1:0] st_addr,
    input logic [3:0]      st_bytes,
    input logic            st_release,
    input logic            st_tagcheck,
    input logic            base_is_sp,
    input logic            wb_valid,
    input logic            wb_to_sp,
    input logic [XLEN-1:0] wb_value,
    input logic            undef_o,
    input logic            nop_o,
    input logic            align_fault,
    input logic            no_match
);
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_valid, undef_o, nop_o, align_fault, no_match}));

    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> st_release);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !(st_valid || undef_o || nop_o || align_fault || no_match));

    p_wb_follows_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (st_valid && wb_value == st_addr));

    p_predec_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> st_tagcheck);

    p_wb_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_to_sp == base_is_sp));

    p_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_bytes == 4'd4 || st_bytes == 4'd8));

    p_sp_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && base_is_sp) |-> ($past(sp_value[SP_ALIGN_BITS-1:0]) == '0));
endmodule

bind srel_decode_unit srel_decode_unit_chk #(.XLEN(XLEN), .SP_ALIGN_BITS(SP_ALIGN_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .sp_value    (sp_value),
    .st_valid    (st_valid),
    .st_addr     (st_addr),
    .st_bytes    (st_bytes),
    .st_release  (st_release),
    .st_tagcheck (st_tagcheck),
    .base_is_sp  (base_is_sp),
    .wb_valid    (wb_valid),
    .wb_to_sp    (wb_to_sp),
    .wb_value    (wb_value),
    .undef_o     (undef_o),
    .nop_o       (nop_o),
    .align_fault (align_fault),
    .no_match    (no_match)
);

// File: tb/srel_decode_unit_tb.sv
module srel_decode_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        feat_preidx_en = 1'b0;
    logic [1:0]  ovl_policy = '0;
    logic [63:0] sp_value = '0;
    logic [4:0]  rd_base_idx, rd_src_idx;
    logic [63:0] rf_base_data, rf_src_data;
    logic        st_valid, st_release, st_tagcheck, base_is_sp;
    logic [63:0] st_addr, st_data, wb_value;
    logic [3:0]  st_bytes;
    logic        wb_valid, wb_to_sp, undef_o, nop_o, align_fault, no_match;
    logic [4:0]  wb_idx;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    function automatic logic [63:0] base_of(input logic [4:0] i);
        return 64'h0000_4000_0000_0000 + {51'd0, i, 8'h00};
    endfunction
    function automatic logic [63:0] src_of(input logic [4:0] i);
        return {27'h5A5A5A5, i, 27'h3C3C3C3, i};
    endfunction

    assign rf_base_data = base_of(rd_base_idx);
    assign rf_src_data  = src_of(rd_src_idx);

    srel_decode_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .feat_preidx_en(feat_preidx_en), .ovl_policy(ovl_policy), .sp_value(sp_value),
        .rd_base_idx(rd_base_idx), .rd_src_idx(rd_src_idx),
        .rf_base_data(rf_base_data), .rf_src_data(rf_src_data),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_bytes(st_bytes),
        .st_release(st_release), .st_tagcheck(st_tagcheck), .base_is_sp(base_is_sp),
        .wb_valid(wb_valid), .wb_to_sp(wb_to_sp), .wb_idx(wb_idx), .wb_value(wb_value),
        .undef_o(undef_o), .nop_o(nop_o), .align_fault(align_fault), .no_match(no_match)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // form: 0 none, 1 plain, 2 pre-decrement
    task automatic run_vec(input logic [31:0] w, input int form, input logic v,
                           input logic feat, input logic [1:0] pol, input logic [63:0] spv);
        logic [4:0] rn, rt;
        logic dw, ovl, zero;
        logic [63:0] base, addr, data;
        logic [4:0] flags;
        string req;
        rn = w[9:5]; rt = w[4:0]; dw = w[30];
        instr = w; instr_valid = v; feat_preidx_en = feat; ovl_policy = pol; sp_value = spv;
        #1;
        chk(rd_base_idx == rn && rd_src_idx == rt, "R2 read indices", {rd_base_idx, rd_src_idx}, {rn, rt});
        base = (rn == 5'd31) ? spv : base_of(rn);
        addr = (form == 2) ? base - (dw ? 64'd8 : 64'd4) : base;
        ovl  = (form == 2) && (rn == rt) && (rn != 5'd31);
        zero = ovl && (pol == 2'd1);
        data = zero ? 64'd0 : (dw ? src_of(rt) : {32'd0, src_of(rt)[31:0]});
        // flags: {store, undef, nop, align, nomatch}
        if (!v)                                   begin flags = 5'b00000; req = "R10 idle"; end
        else if (form == 0)                       begin flags = 5'b00001; req = "R9 no match"; end
        else if (form == 2 && !feat)              begin flags = 5'b01000; req = "R4 feature off"; end
        else if (ovl && pol == 2'd2)              begin flags = 5'b01000; req = "R5 overlap undef"; end
        else if (ovl && pol == 2'd3)              begin flags = 5'b00100; req = "R5 overlap nop"; end
        else if (rn == 5'd31 && spv[3:0] != 4'd0) begin flags = 5'b00010; req = "R8 sp misaligned"; end
        else                                      begin flags = 5'b10000; req = (form == 1) ? "R1 plain store" : "R2 predec store"; end
        @(posedge clk);
        @(negedge clk);
        chk({st_valid, undef_o, nop_o, align_fault, no_match} == flags, req,
            {59'd0, st_valid, undef_o, nop_o, align_fault, no_match}, {59'd0, flags});
        chk(wb_valid == (flags[4] && form == 2), "R1 R2 writeback presence", {63'd0, wb_valid}, {63'd0, flags[4] && form == 2});
        if (flags[4]) begin
            chk(st_addr == addr, form == 1 ? "R1 address" : "R2 address", st_addr, addr);
            chk(st_data == data, zero ? "R5 zero data" : "R3 data", st_data, data);
            chk(st_bytes == (dw ? 4'd8 : 4'd4), "R3 bytes", {60'd0, st_bytes}, dw ? 64'd8 : 64'd4);
            chk(st_release, "R10 release flag", {63'd0, st_release}, 64'd1);
            chk(st_tagcheck == ((form == 2) || rn != 5'd31), "R6 tag check",
                {63'd0, st_tagcheck}, {63'd0, (form == 2) || rn != 5'd31});
            chk(base_is_sp == (rn == 5'd31), "R7 base is sp", {63'd0, base_is_sp}, {63'd0, rn == 5'd31});
            if (form == 2) begin
                chk(wb_value == addr && wb_idx == rn, "R2 writeback value", wb_value, addr);
                chk(wb_to_sp == (rn == 5'd31), "R7 writeback to sp", {63'd0, wb_to_sp}, {63'd0, rn == 5'd31});
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R11 reset state
        chk({st_valid, wb_valid, undef_o, nop_o, align_fault, no_match} == 6'd0, "R11 reset flags",
            {58'd0, st_valid, wb_valid, undef_o, nop_o, align_fault, no_match}, 64'd0);
        rst_n = 1'b1;
        for (int f = 1; f <= 2; f++)
            for (int dw = 0; dw < 2; dw++)
                for (int rn = 0; rn < 32; rn++)
                    for (int rt = 0; rt < 32; rt++)
                        for (int p = 0; p < 4; p++)
                            for (int fe = 0; fe < 2; fe++)
                                for (int s = 0; s < 2; s++) begin
                                    logic [31:0] w;
                                    if (f == 1) w = {1'b1, dw[0], 9'b001000100, 5'h1F, 1'b1, 5'h1F, rn[4:0], rt[4:0]};
                                    else        w = {1'b1, dw[0], 8'b01100110, 10'd0, 2'b10, rn[4:0], rt[4:0]};
                                    run_vec(w, f, 1'b1, fe[0], p[1:0], 64'h0000_7FFF_FFFF_FF00 + (s == 1 ? 64'd8 : 64'd0));
                                end
        // R9: single-bit corruptions of both encodings in the fixed fields
        for (int f = 1; f <= 2; f++)
            for (int b = 10; b < 32; b++) begin
                logic [31:0] w;
                if (b == 30) continue;
                w = (f == 1) ? {1'b1, 1'b1, 9'b001000100, 5'h1F, 1'b1, 5'h1F, 5'd3, 5'd7}
                             : {1'b1, 1'b1, 8'b01100110, 10'd0, 2'b10, 5'd3, 5'd7};
                w[b] = ~w[b];
                run_vec(w, 0, 1'b1, 1'b1, 2'd0, 64'h0000_7FFF_FFFF_FF00);
            end
        // R10: matching word with instr_valid low yields nothing
        run_vec({1'b1, 1'b1, 8'b01100110, 10'd0, 2'b10, 5'd4, 5'd9}, 2, 1'b0, 1'b1, 2'd0, 64'h100);
        run_vec(32'h0, 0, 1'b0, 1'b1, 2'd0, 64'h100);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule